// File: doc/BRIEF.md
# Bus Power Presence Monitor

This block takes a digitised comparator bit that says whether the remote bus supply is above its trip level. It turns that bit into a qualified, active-low flag for the logic side. A low flag means bus power is present and a high flag means it is absent. Power is declared present quickly. It is declared gone only after a much longer wait. A brief dip or spike on the comparator shorter than the relevant window leaves the flag unchanged.

The raw bit first passes through a two-flop synchroniser. A counter then measures how long the synchronised bit has disagreed with the current flag, and the flag flips only when the counter reaches the window for the current direction. Both windows are parameters counted in clock cycles. A separate link-valid input tells the block whether the isolated side is alive. While that input is low, the flag is held at "no power".

Top module: `busPwrMon`

## Requirements
- R1: A synchronous reset drives pwrN high (no power), clears the qualification counter and clears both synchroniser stages.
- R2: pwrN is active low: 0 means bus power is present and 1 means bus power is absent. With the comparator held at 0, pwrN stays 1.
- R3: The comparator bit reaches the qualification logic through exactly two synchroniser flops. After reset is released with cmpRaw already 1, pwrN falls on the ENABLE_CYC+2'th rising edge.
- R4: When cmpRaw rises and stays at 1 while link is valid, pwrN falls exactly ENABLE_CYC+2 rising edges after the change. It is still 1 after ENABLE_CYC+1 edges.
- R5: When cmpRaw falls and stays at 0 while link is valid, pwrN rises exactly DISABLE_CYC+2 rising edges after the change. It is still 0 after DISABLE_CYC+1 edges.
- R6: A high pulse on cmpRaw lasting ENABLE_CYC-1 cycles or fewer, starting from the absent state, leaves pwrN at 1.
- R7: A low pulse on cmpRaw lasting DISABLE_CYC-1 cycles or fewer, starting from the present state, leaves pwrN at 0.
- R8: While linkOk is 0, pwrN is 1 from the first rising edge that samples linkOk low, and the counter is held at zero. When linkOk returns to 1 with the synchronised bit already at 1, pwrN falls after exactly ENABLE_CYC edges.
- R9: Any cycle in which the synchronised bit agrees with the flag clears the counter. After an aborted change, the next change needs its full window again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| linkOk | input | 1 | 1 while the isolated side is powered and its data is trusted |
| cmpRaw | input | 1 | Raw comparator bit, 1 when the bus supply is above its trip level |
| pwrN | output | 1 | Qualified flag, 0 when bus power is present |

## Verification
On every cycle, the assertions check the following:
- Reset and a dead link each force the flag high on the next edge.
- The flag changes only when the counter has reached the window for its direction.
- Any cycle of agreement leaves the flag unchanged and clears the counter.

The exact edge counts at the port can only be shown by the bench's scenarios. These cover the ENABLE_CYC+2 and DISABLE_CYC+2 latencies, which include the synchroniser. They also cover pulses one cycle shorter than each window and the full delay after the link returns or reset is released.

// File: rtl/bus_pwr_pkg.sv
package busPwrPkg;

  typedef enum logic {
    ST_ABSENT  = 1'b0,
    ST_PRESENT = 1'b1
  } pwrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;      // counter back to zero
    logic incCnt;      // counter plus one
    logic selRelease;  // compare against the release window
  } cntCtl_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bus_pwr_dp.sv
module busPwrDp
  import busPwrPkg::*;
#(
  parameter int ENABLE_CYC  = 37500,
  parameter int DISABLE_CYC = 1250000,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(maxOf(ENABLE_CYC, DISABLE_CYC) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmpRaw,
  input  cntCtl_t          ctl,
  output logic             syncBit,
  output logic [CNT_W-1:0] cntVal,
  output logic             cntHit
);

  localparam logic [CNT_W-1:0] ENA_LAST = CNT_W'(ENABLE_CYC - 1);
  localparam logic [CNT_W-1:0] REL_LAST = CNT_W'(DISABLE_CYC - 1);

  logic [SYNC_STAGES-1:0] syncReg;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : gSync
      if (i == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (rst) syncReg[0] <= 1'b0;
          else     syncReg[0] <= cmpRaw;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (rst) syncReg[i] <= 1'b0;
          else     syncReg[i] <= syncReg[i-1];
        end
      end
    end
  endgenerate

  assign syncBit = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst || ctl.clrCnt) cntVal <= '0;
    else if (ctl.incCnt)   cntVal <= cntVal + 1'b1;
  end

  assign cntHit = (cntVal == (ctl.selRelease ? REL_LAST : ENA_LAST));

endmodule

// File: rtl/bus_pwr_ctl.sv
module busPwrCtl
  import busPwrPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    linkOk,
  input  logic    syncBit,
  input  logic    cntHit,
  output cntCtl_t ctl,
  output logic    pwrN
);

  pwrState_t state, stateNext;
  logic present, disagree;

  assign present  = (state == ST_PRESENT);
  assign disagree = (syncBit != present);

  always_comb begin
    stateNext      = state;
    ctl.selRelease = present;
    ctl.clrCnt     = 1'b0;
    ctl.incCnt     = 1'b0;
    if (!linkOk) begin
      stateNext  = ST_ABSENT;
      ctl.clrCnt = 1'b1;
    end else if (disagree) begin
      if (cntHit) begin
        stateNext  = present ? ST_ABSENT : ST_PRESENT;
        ctl.clrCnt = 1'b1;
      end else begin
        ctl.incCnt = 1'b1;
      end
    end else begin
      ctl.clrCnt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_ABSENT;
    else     state <= stateNext;
  end

  assign pwrN = ~present;

endmodule

// File: rtl/bus_pwr_mon.sv
module busPwrMon
  import busPwrPkg::*;
#(
  parameter int ENABLE_CYC  = 37500,
  parameter int DISABLE_CYC = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic linkOk,
  input  logic cmpRaw,
  output logic pwrN
);

  localparam int CNT_W = $clog2(maxOf(ENABLE_CYC, DISABLE_CYC) + 1);

  cntCtl_t          ctl;
  logic             syncBit;
  logic             cntHit;
  logic [CNT_W-1:0] cntVal;

  busPwrDp #(
    .ENABLE_CYC (ENABLE_CYC),
    .DISABLE_CYC(DISABLE_CYC),
    .SYNC_STAGES(2)
  ) uDp (
    .clk    (clk),
    .rst    (rst),
    .cmpRaw (cmpRaw),
    .ctl    (ctl),
    .syncBit(syncBit),
    .cntVal (cntVal),
    .cntHit (cntHit)
  );

  busPwrCtl uCtl (
    .clk    (clk),
    .rst    (rst),
    .linkOk (linkOk),
    .syncBit(syncBit),
    .cntHit (cntHit),
    .ctl    (ctl),
    .pwrN   (pwrN)
  );

endmodule

// File: rtl/bus_pwr_mon_chk.sv
module busPwrMonChk
  import busPwrPkg::*;
#(
  parameter int ENABLE_CYC  = 37500,
  parameter int DISABLE_CYC = 1250000,
  localparam int CNT_W = $clog2(maxOf(ENABLE_CYC, DISABLE_CYC) + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             linkOk,
  input logic             pwrN,
  input logic             syncBit,
  input logic [CNT_W-1:0] cntVal
);

  AST_RESET_ABSENT: assert property (@(posedge clk)
    rst |=> (pwrN && cntVal == '0)); // R1

  AST_LINK_SAFE: assert property (@(posedge clk) disable iff (rst)
    !linkOk |=> (pwrN && cntVal == '0)); // R8

  AST_ASSERT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $fell(pwrN) |-> $past(cntVal) == CNT_W'(ENABLE_CYC - 1)); // R4

  AST_RELEASE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ($rose(pwrN) && $past(linkOk)) |-> $past(cntVal) == CNT_W'(DISABLE_CYC - 1)); // R5

  AST_HOLD_ON_AGREE: assert property (@(posedge clk) disable iff (rst)
    (linkOk && (syncBit == !pwrN)) |=> ($stable(pwrN) && cntVal == '0)); // R9

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cntVal < CNT_W'(maxOf(ENABLE_CYC, DISABLE_CYC))); // R7

endmodule

bind busPwrMon busPwrMonChk #(
  .ENABLE_CYC (ENABLE_CYC),
  .DISABLE_CYC(DISABLE_CYC)
) uChk (
  .clk    (clk),
  .rst    (rst),
  .linkOk (linkOk),
  .pwrN   (pwrN),
  .syncBit(syncBit),
  .cntVal (cntVal)
);

// File: tb/sim_busPwrMon.sv
`timescale 1ns/1ps
module sim_busPwrMon;

  localparam int ENA = 6;
  localparam int REL = 20;
  localparam int VEC_N = 11;

  // vector: comparator level, cycles to hold, expected pwrN, requirement
  localparam bit vRaw [VEC_N] = '{0, 1, 1, 0, 0, 1, 0, 1, 0, 1, 0};
  localparam int vCyc [VEC_N] = '{
    10,        // R2 idle, no power
    ENA + 1,   // R4 one edge short
    1,         // R4 exact edge
    REL + 1,   // R5 one edge short
    1,         // R5 exact edge
    ENA - 1,   // R6 short high pulse
    12,        // R6 pulse gone
    ENA + 2,   // R9 full window after abort
    REL - 1,   // R7 short low pulse
    10,        // R7 back high, still present
    REL + 2    // R5 full release
  };
  localparam bit vExp [VEC_N] = '{1, 1, 0, 0, 1, 1, 1, 0, 0, 0, 1};
  localparam int vReq [VEC_N] = '{2, 4, 4, 5, 5, 6, 6, 9, 7, 7, 5};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic linkOk = 1'b1;
  logic cmpRaw = 1'b0;
  logic pwrN;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  busPwrMon #(.ENABLE_CYC(ENA), .DISABLE_CYC(REL)) u0 (
    .clk   (clk),
    .rst   (rst),
    .linkOk(linkOk),
    .cmpRaw(cmpRaw),
    .pwrN  (pwrN)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit exp, input string req);
    total++;
    if (pwrN !== exp) begin
      bad++;
      $display("FAIL %s pwrN=%0b expected %0b at %0t", req, pwrN, exp, $time);
    end
  endtask

  initial begin
    @(negedge clk);
    step(2);
    check(1'b1, "R1 reset state");
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < VEC_N; i++) begin
      cmpRaw = vRaw[i];
      step(vCyc[i]);
      check(vExp[i], $sformatf("R%0d vector %0d", vReq[i], i));
    end

    // R8 link loss and return
    cmpRaw = 1'b1;
    step(ENA + 2);
    check(1'b0, "R4 present before link loss");
    linkOk = 1'b0;
    step(1);
    check(1'b1, "R8 link loss forces absent");
    step(4);
    check(1'b1, "R8 held absent while link down");
    linkOk = 1'b1;
    step(ENA - 1);
    check(1'b1, "R8 one edge short after link back");
    step(1);
    check(1'b0, "R8 full window after link back");

    // R1 and R3 reset mid-run and synchroniser latency
    rst = 1'b1;
    step(1);
    check(1'b1, "R1 reset while present");
    step(2);
    rst = 1'b0;
    step(ENA + 1);
    check(1'b1, "R3 one edge short after reset");
    step(1);
    check(1'b0, "R3 exact latency after reset");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule